// File: doc/BRIEF.md
# Byte Programming Sequencer with Pulse-and-Verify

This controller writes a byte image from a source read port into a one-time-style programmable memory. A single `start` pulse begins the run. The controller raises both raised-supply flags and starts at address zero. For each address it presents the address and the source byte. After a setup interval it applies a program pulse of fixed width. It then reads the byte back in verify mode and compares it with the source byte. On a mismatch it pulses the same address again, up to a fixed limit. A byte that matches moves the sequencer to the next address.

After the last address has been programmed, the controller drops the program-voltage flag first and the raised-core-supply flag one cycle later. It then reads every location again under normal supply and compares each byte with the image. The run ends with `done` and either `pass` or `fail`. On a failure, the failing address and the byte that was read are held on the status outputs. Generating the supplies themselves is outside this block; `vpp_en` and `vcc_prog_en` only request them.

Top module: `burn_seq`

## Requirements
- R1: After reset, `mem_ce_n` and `mem_oe_n` are 1, `mem_dout_en`, `vpp_en`, `vcc_prog_en`, `done`, `pass` and `fail` are 0.
- R2: A `start` pulse while idle clears the result, sets `vpp_en` and `vcc_prog_en` together and begins programming at address 0 with the pulse count at zero.
- R3: A program pulse is `mem_ce_n`=0 with `mem_oe_n`=1, `vpp_en`=1 and `mem_dout_en`=1. It lasts exactly PULSE_CYC = CLK_HZ*PULSE_US/1e6 cycles. Address and data are held for SETUP_CYC cycles before the pulse and stay unchanged during it.
- R4: After every pulse the byte is read back with `mem_ce_n`=1, `mem_oe_n`=0, `vpp_en`=1 and data not driven. `mem_din` is sampled in the VER_CYC-th cycle of that read. A mismatch with `src_data` leads to a further pulse at the same address.
- R5: No address receives more than MAX_PULSES (25) pulses. If the verify after the 25th pulse still mismatches, the run ends with `done`=1, `fail`=1, `fail_addr` set to that address and `fail_data` set to the byte read. No later address is pulsed.
- R6: A verify match moves to the next address with the pulse count back at zero. A byte that already reads back correctly after its first pulse takes exactly one pulse.
- R7: `vpp_en` is never 1 while `vcc_prog_en` is 0. When programming completes, `vpp_en` falls exactly one cycle before `vcc_prog_en`.
- R8: The final pass reads every address from 0 to the last one with `mem_ce_n`=0, `mem_oe_n`=0 and both supply flags at 0. The first mismatch ends the run with `fail`, `fail_addr` and `fail_data`. If there is no mismatch, the run ends with `pass`.
- R9: `done`, `pass`, `fail`, `fail_addr` and `fail_data` hold until the next `start`. The memory stays deselected after the run. A `start` during a run has no effect.
- R10: `pass` and `fail` are never 1 together, and `done` is 1 exactly when one of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming run when idle |
| src_addr | output | ADDR_W | Address presented to the image source |
| src_data | input | 8 | Image byte for `src_addr`, combinational |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dout | output | 8 | Byte driven to the memory data pins |
| mem_dout_en | output | 1 | Data pins driven by the controller |
| mem_din | input | 8 | Byte read from the memory data pins |
| vpp_en | output | 1 | Request for the program voltage |
| vcc_prog_en | output | 1 | Request for the raised core supply |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with every byte correct |
| fail | output | 1 | Run finished with an error |
| fail_addr | output | ADDR_W | Address of the failure |
| fail_data | output | 8 | Byte read at the failure |

## Verification
The bench models the memory so that each location needs a chosen number of pulses before its bits take. This covers a byte needing exactly 25 pulses, which must pass, and one needing 26, which must fail. A design that is off by one on the limit either fails the first case or pulses the second a 26th time. A location that reads correctly under raised supply but corrupts under normal supply must be caught in the final pass, including at the last address. A design that skips or shortens that pass would report `pass`. Supply ordering, pulse width and a stray `start` mid-run are also checked: a design that drops both flags at once on success, or restarts on the second `start`, shows wrong timestamps or extra pulses.

// File: rtl/burn_seq.sv
module burn_seq #(
  parameter int ADDR_W     = 15,
  parameter int CLK_HZ     = 50_000_000,
  parameter int PULSE_US   = 100,
  parameter int SETUP_CYC  = 2,
  parameter int VER_CYC    = 2,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] src_addr,
  input  logic [7:0]        src_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic [7:0]        mem_dout,
  output logic              mem_dout_en,
  input  logic [7:0]        mem_din,
  output logic              vpp_en,
  output logic              vcc_prog_en,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [7:0]        fail_data
);
  localparam int PULSE_CYC = CLK_HZ / 1000 * PULSE_US / 1000;
  localparam int TW = $clog2(PULSE_CYC + SETUP_CYC + VER_CYC + 1);
  localparam int CW = $clog2(MAX_PULSES + 1);
  localparam logic [ADDR_W-1:0] LAST = '1;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_PULSE, S_VWAIT, S_VPP_OFF, S_VCC_OFF, S_READ} st_t;

  st_t               st;
  logic [ADDR_W-1:0] addr;
  logic [TW-1:0]     tmr;
  logic [CW-1:0]     cnt;
  logic              tmr_end;
  logic              match;

  always_comb begin
    case (st)
      S_SETUP:        tmr_end = (tmr == TW'(SETUP_CYC - 1));
      S_PULSE:        tmr_end = (tmr == TW'(PULSE_CYC - 1));
      S_VWAIT, S_READ: tmr_end = (tmr == TW'(VER_CYC - 1));
      default:        tmr_end = 1'b1;
    endcase
  end

  assign match       = (mem_din == src_data);
  assign src_addr    = addr;
  assign mem_addr    = addr;
  assign mem_dout    = src_data;
  assign mem_dout_en = (st == S_SETUP) || (st == S_PULSE);
  assign mem_ce_n    = !((st == S_PULSE) || (st == S_READ));
  assign mem_oe_n    = !((st == S_VWAIT) || (st == S_READ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      addr        <= '0;
      tmr         <= '0;
      cnt         <= '0;
      vpp_en      <= 1'b0;
      vcc_prog_en <= 1'b0;
      done        <= 1'b0;
      pass        <= 1'b0;
      fail        <= 1'b0;
      fail_addr   <= '0;
      fail_data   <= '0;
    end else begin
      tmr <= tmr_end ? '0 : tmr + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st          <= S_SETUP;
          addr        <= '0;
          cnt         <= '0;
          done        <= 1'b0;
          pass        <= 1'b0;
          fail        <= 1'b0;
          vpp_en      <= 1'b1;
          vcc_prog_en <= 1'b1;
        end
        S_SETUP: if (tmr_end) st <= S_PULSE;
        S_PULSE: if (tmr_end) begin
          st  <= S_VWAIT;
          cnt <= cnt + 1'b1;
        end
        S_VWAIT: if (tmr_end) begin
          if (match) begin
            cnt <= '0;
            if (addr == LAST) st <= S_VPP_OFF;
            else begin
              addr <= addr + 1'b1;
              st   <= S_SETUP;
            end
          end else if (cnt == CW'(MAX_PULSES)) begin
            st          <= S_IDLE;
            done        <= 1'b1;
            fail        <= 1'b1;
            fail_addr   <= addr;
            fail_data   <= mem_din;
            vpp_en      <= 1'b0;
            vcc_prog_en <= 1'b0;
          end else st <= S_SETUP;
        end
        S_VPP_OFF: begin
          vpp_en <= 1'b0;
          st     <= S_VCC_OFF;
        end
        S_VCC_OFF: begin
          vcc_prog_en <= 1'b0;
          addr        <= '0;
          st          <= S_READ;
        end
        S_READ: if (tmr_end) begin
          if (!match) begin
            st        <= S_IDLE;
            done      <= 1'b1;
            fail      <= 1'b1;
            fail_addr <= addr;
            fail_data <= mem_din;
          end else if (addr == LAST) begin
            st   <= S_IDLE;
            done <= 1'b1;
            pass <= 1'b1;
          end else addr <= addr + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/burn_seq_chk.sv
module burn_seq_chk #(
  parameter int ADDR_W     = 15,
  parameter int PULSE_CYC  = 5000,
  parameter int SETUP_CYC  = 2,
  parameter int MAX_PULSES = 25
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic [7:0]        mem_dout,
  input logic              mem_dout_en,
  input logic              vpp_en,
  input logic              vcc_prog_en,
  input logic              done,
  input logic              pass,
  input logic              fail
);
  logic              in_pulse, pulse_q, vpp_q;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        dout_q;
  int                low_cnt, stab_cnt, per_addr;

  assign in_pulse = !mem_ce_n && mem_oe_n && vpp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q  <= 1'b0;
      vpp_q    <= 1'b0;
      addr_q   <= '0;
      dout_q   <= '0;
      low_cnt  <= 0;
      stab_cnt <= 0;
      per_addr <= 0;
    end else begin
      pulse_q <= in_pulse;
      vpp_q   <= vpp_en;
      addr_q  <= mem_addr;
      dout_q  <= mem_dout;
      low_cnt <= in_pulse ? low_cnt + 1 : 0;
      if (mem_addr != addr_q || mem_dout != dout_q) stab_cnt <= 0;
      else if (stab_cnt < SETUP_CYC) stab_cnt <= stab_cnt + 1;
      if (mem_addr != addr_q || (vpp_en && !vpp_q)) per_addr <= 0;
      else if (in_pulse && !pulse_q) per_addr <= per_addr + 1;
    end
  end

  AST_PGM_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (!mem_ce_n && vpp_en) |-> (mem_oe_n && mem_dout_en)); // R3
  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n) (!in_pulse && pulse_q) |-> (low_cnt == PULSE_CYC)); // R3
  AST_SETUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (in_pulse && !pulse_q) |-> (stab_cnt >= SETUP_CYC - 1)); // R3
  AST_PULSE_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (in_pulse && pulse_q) |-> ($stable(mem_addr) && $stable(mem_dout))); // R3
  AST_VERIFY_MODE: assert property (@(posedge clk) disable iff (!rst_n) (!mem_oe_n && vpp_en) |-> (mem_ce_n && !mem_dout_en)); // R4
  AST_PULSE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) per_addr <= MAX_PULSES); // R5
  AST_VPP_NEEDS_VCC: assert property (@(posedge clk) disable iff (!rst_n) vpp_en |-> vcc_prog_en); // R7
  AST_VCC_DROP_ORDER: assert property (@(posedge clk) disable iff (!rst_n) $fell(vcc_prog_en) |-> !vpp_en); // R7
  AST_FINAL_READ: assert property (@(posedge clk) disable iff (!rst_n) (!mem_oe_n && !mem_ce_n) |-> (!vpp_en && !vcc_prog_en)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) done |-> (mem_ce_n && mem_oe_n && !vpp_en)); // R9
  AST_RESULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(pass && fail)); // R10
  AST_DONE_MEANS: assert property (@(posedge clk) disable iff (!rst_n) done == (pass || fail)); // R10
endmodule

bind burn_seq burn_seq_chk #(
  .ADDR_W(ADDR_W), .PULSE_CYC(PULSE_CYC), .SETUP_CYC(SETUP_CYC), .MAX_PULSES(MAX_PULSES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
  .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .vpp_en(vpp_en), .vcc_prog_en(vcc_prog_en),
  .done(done), .pass(pass), .fail(fail)
);

// File: tb/sim_burn_seq.sv
module sim_burn_seq;
  localparam int AW = 4;
  localparam int N = 1 << AW;
  localparam int PW = 20;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] src_addr, mem_addr, fail_addr;
  logic [7:0] src_data, mem_dout, mem_din, fail_data;
  logic mem_ce_n, mem_oe_n, mem_dout_en, vpp_en, vcc_prog_en, done, pass, fail;

  always #10 clk = ~clk;

  burn_seq #(.ADDR_W(AW), .CLK_HZ(200_000), .PULSE_US(100), .SETUP_CYC(2), .VER_CYC(2), .MAX_PULSES(25)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr), .src_data(src_data),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_dout(mem_dout),
    .mem_dout_en(mem_dout_en), .mem_din(mem_din), .vpp_en(vpp_en), .vcc_prog_en(vcc_prog_en),
    .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr), .fail_data(fail_data));

  logic [7:0] cells [N];
  logic [7:0] src [N];
  int need [N], pcnt [N], ep [N];
  int leak = -1;
  int total = 0, bad = 0, cyc = 0;
  int run_len = 0, pw_min = 0, pw_max = 0, t_vpp = 0, t_vcc = 0;
  int sup_bad = 0, vmode_bad = 0, rd_bad = 0;
  logic ce_q = 1'b1, vpp_q = 1'b0, vcc_q = 1'b0;
  bit exp_fail;
  int exp_addr, exp_data;

  assign src_data = src[src_addr];
  assign mem_din = (!vcc_prog_en && leak == int'(mem_addr)) ? (cells[mem_addr] ^ 8'h01) : cells[mem_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    ce_q <= mem_ce_n;
    vpp_q <= vpp_en;
    vcc_q <= vcc_prog_en;
    if (ce_q && !mem_ce_n && mem_oe_n && vpp_en) begin
      pcnt[mem_addr] <= pcnt[mem_addr] + 1;
      if (pcnt[mem_addr] + 1 >= need[mem_addr]) cells[mem_addr] <= cells[mem_addr] & mem_dout;
    end
    if (!mem_ce_n && mem_oe_n && vpp_en) run_len <= run_len + 1;
    else if (run_len > 0) begin
      if (pw_min == 0 || run_len < pw_min) pw_min <= run_len;
      if (run_len > pw_max) pw_max <= run_len;
      run_len <= 0;
    end
    if (vpp_q && !vpp_en) t_vpp <= cyc;
    if (vcc_q && !vcc_prog_en) t_vcc <= cyc;
    if (vpp_en && !vcc_prog_en) sup_bad <= sup_bad + 1;
    if (!mem_oe_n && vpp_en && (!mem_ce_n || mem_dout_en)) vmode_bad <= vmode_bad + 1;
    if (!mem_oe_n && !mem_ce_n && (vpp_en || vcc_prog_en)) rd_bad <= rd_bad + 1;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic init_mem(input int nmax);
    for (int a = 0; a < N; a++) begin
      cells[a] = 8'hFF;
      pcnt[a] = 0;
      src[a] = 8'($urandom);
      need[a] = 1 + int'($urandom % nmax);
    end
    leak = -1;
  endtask

  task automatic compute_exp();
    bit stop = 0;
    exp_fail = 0;
    exp_addr = 0;
    exp_data = 0;
    for (int a = 0; a < N; a++) begin
      if (stop) ep[a] = 0;
      else if (src[a] == 8'hFF) ep[a] = 1;
      else if (need[a] <= 25) ep[a] = need[a];
      else begin
        ep[a] = 25;
        stop = 1;
        exp_fail = 1;
        exp_addr = a;
        exp_data = 8'hFF;
      end
    end
    if (!stop && leak >= 0) begin
      exp_fail = 1;
      exp_addr = leak;
      exp_data = int'(src[leak] ^ 8'h01);
    end
  endtask

  task automatic run_prog(input bit mid);
    int n = 0;
    compute_exp();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && n < 60000) begin
      @(negedge clk);
      n++;
      start = (mid && n == 40);
    end
    start = 1'b0;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog: got done=0 expected done=1");
    end
  endtask

  task automatic check_result(input string tag);
    int mism = 0, first = -1;
    chk(done == 1'b1, "R9", {tag, " done"}, int'(done), 1);
    chk(fail == exp_fail, exp_fail ? "R5" : "R8", {tag, " fail"}, int'(fail), int'(exp_fail));
    chk(pass == !exp_fail, "R10", {tag, " pass"}, int'(pass), int'(!exp_fail));
    if (exp_fail) begin
      chk(int'(fail_addr) == exp_addr, "R8", {tag, " fail_addr"}, int'(fail_addr), exp_addr);
      chk(int'(fail_data) == exp_data, "R8", {tag, " fail_data"}, int'(fail_data), exp_data);
    end
    for (int a = 0; a < N; a++)
      if (pcnt[a] != ep[a]) begin
        mism++;
        if (first < 0) first = a;
      end
    chk(mism == 0, "R6", {tag, " pulses per address"}, first < 0 ? 0 : pcnt[first], first < 0 ? 0 : ep[first]);
    chk(pw_min == PW && pw_max == PW, "R3", {tag, " pulse width"}, pw_max, PW);
    chk(vmode_bad == 0, "R4", {tag, " verify mode pins"}, vmode_bad, 0);
    chk(rd_bad == 0, "R8", {tag, " final read pins"}, rd_bad, 0);
    chk(sup_bad == 0, "R7", {tag, " vpp without vcc"}, sup_bad, 0);
    if (!exp_fail || leak >= 0)
      chk(t_vcc - t_vpp == 1, "R7", {tag, " supply drop order"}, t_vcc - t_vpp, 1);
    repeat (20) @(negedge clk);
    chk(done && pass == !exp_fail && fail == exp_fail && mem_ce_n && mem_oe_n && !vpp_en,
        "R9", {tag, " result held"}, int'({done, pass, fail, mem_ce_n, mem_oe_n}), int'({1'b1, !exp_fail, exp_fail, 2'b11}));
  endtask

  initial begin
    void'($urandom(32'd2024));
    init_mem(4);
    repeat (3) @(negedge clk);
    chk(!done && !pass && !fail && mem_ce_n && mem_oe_n && !vpp_en && !vcc_prog_en && !mem_dout_en,
        "R1", "reset state", int'({done, pass, fail, mem_ce_n, mem_oe_n, vpp_en, vcc_prog_en, mem_dout_en}), 8'b00011000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk);
    chk(vpp_en && vcc_prog_en && mem_addr == '0 && !done, "R2", "start raises supplies",
        int'({vpp_en, vcc_prog_en, done}), 3'b110);
    while (!done) @(negedge clk);
    repeat (5) @(negedge clk);

    init_mem(4);
    run_prog(1'b1);
    check_result("random with stray start");

    init_mem(3);
    need[7] = 25;
    src[7] = 8'h00;
    run_prog(1'b0);
    check_result("25 pulses boundary");

    init_mem(5);
    need[5] = 26;
    src[5] = 8'h5A;
    run_prog(1'b0);
    check_result("pulse limit exceeded");

    init_mem(3);
    leak = 11;
    run_prog(1'b0);
    check_result("final read mismatch");

    init_mem(6);
    for (int a = 0; a < N; a++) src[a] = 8'hFF;
    leak = N - 1;
    run_prog(1'b0);
    check_result("erased image, last address leak");

    init_mem(25);
    src[0] = 8'h81;
    need[0] = 26;
    run_prog(1'b0);
    check_result("fail at first address");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule